// File: doc/BRIEF.md
# Serial SAR converter readout controller

This block reads one result from a successive-approximation converter with a three-wire serial interface. When `start` pulses, it pulls chip select low and produces a serial clock from the system clock. The half-period of that clock is set by the `div` input, so the clock rate can be held at or below about 2 MHz whatever the system clock is. The data line idles high through a pull-up. The controller keeps clocking until it samples the first zero, and that zero marks the start of the frame. It then shifts in the result most significant bit first.

Chip select stays low after the first word, and the controller clocks in the same result a second time, least significant bit first. It bit-reverses this second copy and compares it with the first, so that a faulty interface shows up as a mismatch. The result, the mismatch flag and a one-cycle valid strobe appear together on the cycle in which chip select is released. If no start zero arrives within a bounded number of serial clocks, the read ends with a timeout pulse and no valid strobe.

Top module: `sar_readout`

## Requirements
- R1: While `rst_n` is low and after reset is released: `cs_n` is 1, `sclk` is 0, and `valid`, `mismatch`, `timeout` and `busy` are 0.
- R2: `sclk` is 0 whenever `cs_n` is 1. During a read, each high phase of `sclk` lasts exactly `div`+1 system clock cycles.
- R3: `cs_n` changes only while `sclk` is low. Its rise happens on the same cycle that `sclk` falls.
- R4: `sdi` is sampled when `sclk` rises. Every 1 sampled before the first 0 is discarded, and that first 0 is not part of the result.
- R5: The W samples that follow the start zero form `result`, with the first sample in bit W-1 and the last in bit 0.
- R6: The controller then clocks a second copy least significant bit first. With LSB_SHARED=1 the copy is W bits long and starts with bit 0. With LSB_SHARED=0 it is W-1 bits long and starts with bit 1, and bit 0 is taken from the first copy.
- R7: `mismatch` is 1 exactly when a bit of the bit-reversed second copy differs from the first copy.
- R8: `valid` is high for exactly one cycle per completed read, on the same cycle that `cs_n` rises. `result` and `mismatch` are updated on that cycle, and `result` changes on no other cycle.
- R9: If HUNT_MAX consecutive 1s are sampled without a zero, `cs_n` rises and `timeout` pulses for one cycle. `valid` stays 0 and `result` keeps its old value. HUNT_MAX-1 leading 1s still give a valid read.
- R10: A `start` pulse that arrives while a read is in progress has no effect: no second frame begins and no extra `valid` appears.
- R11: `busy` is 1 from the cycle after an accepted `start` until the cycle on which `cs_n` rises, and `cs_n` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read (ignored while busy) |
| div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sdi | input | 1 | Serial data from the converter, pulled high when idle |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| result | output | W | Last valid result |
| valid | output | 1 | One-cycle strobe marking a new result |
| mismatch | output | 1 | The two received copies differed |
| timeout | output | 1 | One-cycle strobe: no start zero seen |
| busy | output | 1 | A read is in progress |

## Verification
The bound assertions watch the interface timing on every cycle: the serial clock stays low while chip select is high, chip select moves only while the clock is low, each high phase lasts `div`+1 cycles, the valid and timeout strobes are single-cycle, mutually exclusive and land on the release of chip select, the result changes only on a valid strobe, and chip select is high whenever `busy` is low. Whether the captured word and the mismatch flag are correct depends on the converter's data stream. Only the bench scenarios can show that: a behavioural converter model sends a varying number of leading ones, corrupts chosen bits of the second copy, and runs against both LSB_SHARED settings. Those scenarios also cover the timeout boundary and a start request made during a read.

// File: rtl/sar_readout.sv
module sar_readout #(
  parameter int W          = 12,
  parameter int DIV_W      = 8,
  parameter int HUNT_MAX   = 16,
  parameter bit LSB_SHARED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             sdi,
  output logic             cs_n,
  output logic             sclk,
  output logic [W-1:0]     result,
  output logic             valid,
  output logic             mismatch,
  output logic             timeout,
  output logic             busy
);
  localparam int LSB_N = LSB_SHARED ? W : W - 1;
  localparam int HW    = $clog2(HUNT_MAX + 1);
  localparam int BW    = $clog2(W + 1);

  typedef enum logic [2:0] {IDLE, HUNT, MSB, LSB, FIN, TMO} st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [HW-1:0]    hunt;
  logic [BW-1:0]    bits;
  logic [W-1:0]     msb_sr, lsb_sr, lsb_word;

  generate
    if (LSB_SHARED) begin : g_full
      assign lsb_word = lsb_sr;
    end else begin : g_skip
      assign lsb_word = {lsb_sr[W-1:1], msb_sr[0]};
    end
  endgenerate

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      hunt     <= '0;
      bits     <= '0;
      msb_sr   <= '0;
      lsb_sr   <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      result   <= '0;
      valid    <= 1'b0;
      mismatch <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      if (st == IDLE) begin
        cnt <= '0;
        if (start) begin
          st   <= HUNT;
          cs_n <= 1'b0;
          hunt <= '0;
          bits <= '0;
        end
      end else if (cnt != div) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt  <= '0;
        sclk <= ~sclk;
        if (!sclk) begin
          case (st)
            HUNT: begin
              if (!sdi) st <= MSB;
              else if (hunt == HW'(HUNT_MAX - 1)) st <= TMO;
              else hunt <= hunt + 1'b1;
            end
            MSB: begin
              msb_sr <= {msb_sr[W-2:0], sdi};
              if (bits == BW'(W - 1)) begin
                bits <= '0;
                st   <= LSB;
              end else bits <= bits + 1'b1;
            end
            LSB: begin
              lsb_sr <= {sdi, lsb_sr[W-1:1]};
              if (bits == BW'(LSB_N - 1)) st <= FIN;
              else bits <= bits + 1'b1;
            end
            default: ;
          endcase
        end else if (st == FIN || st == TMO) begin
          cs_n <= 1'b1;
          st   <= IDLE;
          if (st == FIN) begin
            result   <= msb_sr;
            mismatch <= (msb_sr != lsb_word);
            valid    <= 1'b1;
          end else begin
            timeout <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int W     = 12,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div,
  input logic             cs_n,
  input logic             sclk,
  input logic [W-1:0]     result,
  input logic             valid,
  input logic             timeout,
  input logic             busy
);
  logic [DIV_W:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc <= '0;
    else if (!sclk) hc <= '0;
    else hc <= hc + 1'b1;
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R2
  high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hc == {1'b0, div} + 1'b1);
  // R3
  cs_assert_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !sclk);
  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> $fell(sclk));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (valid || timeout) |-> $rose(cs_n));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> valid);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({valid, timeout}));
  // R9
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout);
  // R11
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
endmodule

bind sar_readout sar_readout_chk #(.W(W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .div(div), .cs_n(cs_n), .sclk(sclk),
  .result(result), .valid(valid), .timeout(timeout), .busy(busy)
);

// File: tb/sar_readout_tb_top.sv
module adc_sim #(parameter int W = 12, parameter bit SHARED = 1'b1) (
  input  logic         cs_n,
  input  logic         sclk,
  input  int           lead,
  input  logic [W-1:0] data,
  input  logic [W-1:0] flip,
  output logic         sdi
);
  int idx = 0;

  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) idx = 0;
    else idx = idx + 1;
  end

  function automatic logic bit_at(input int i);
    int j, k;
    if (i < lead) return 1'b1;
    if (i == lead) return 1'b0;
    j = i - lead - 1;
    if (j < W) return data[W-1-j];
    k = j - W;
    if (SHARED) begin
      if (k < W) return data[k] ^ flip[k];
    end else begin
      if (k < W - 1) return data[k+1] ^ flip[k+1];
    end
    return 1'b1;
  endfunction

  always_comb sdi = cs_n ? 1'b1 : bit_at(idx);
endmodule

module sar_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int DIV_W = 8;
  localparam int HUNT_MAX = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DIV_W-1:0] div = '0;
  int lead = 0;
  logic [W-1:0] data = '0, flip_a = '0, flip_b = '0;
  logic sdi_a, sdi_b;
  logic cs_a, sclk_a, val_a, mm_a, to_a, busy_a;
  logic cs_b, sclk_b, val_b, mm_b, to_b, busy_b;
  logic [W-1:0] res_a, res_b;
  int errors = 0, checks = 0;
  logic [W-1:0] prev_a = '0, prev_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_readout #(.W(W), .DIV_W(DIV_W), .HUNT_MAX(HUNT_MAX), .LSB_SHARED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .div(div), .sdi(sdi_a), .cs_n(cs_a),
    .sclk(sclk_a), .result(res_a), .valid(val_a), .mismatch(mm_a), .timeout(to_a), .busy(busy_a));
  sar_readout #(.W(W), .DIV_W(DIV_W), .HUNT_MAX(HUNT_MAX), .LSB_SHARED(1'b0)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .start(start), .div(div), .sdi(sdi_b), .cs_n(cs_b),
    .sclk(sclk_b), .result(res_b), .valid(val_b), .mismatch(mm_b), .timeout(to_b), .busy(busy_b));

  adc_sim #(.W(W), .SHARED(1'b1)) adc_a (.cs_n(cs_a), .sclk(sclk_a), .lead(lead), .data(data), .flip(flip_a), .sdi(sdi_a));
  adc_sim #(.W(W), .SHARED(1'b0)) adc_b (.cs_n(cs_b), .sclk(sclk_b), .lead(lead), .data(data), .flip(flip_b), .sdi(sdi_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_mm(input bit shared, input logic [W-1:0] f);
    return shared ? (f != '0) : (f[W-1:1] != '0);
  endfunction

  task automatic run_frame(input int ld, input logic [W-1:0] d, input logic [W-1:0] fa,
                           input logic [W-1:0] fb, input logic [DIV_W-1:0] dv, input bit poke);
    int va = 0, vb = 0, ta = 0, tb = 0, hr = 0, bad_hr = 0, bad_cs = 0, n = 0, extra = 0;
    logic [W-1:0] ra = '0, rb = '0;
    logic ma = 0, mb = 0, pcs = 1;
    bit to_exp;
    lead = ld; data = d; flip_a = fa; flip_b = fb; div = dv;
    to_exp = (ld >= HUNT_MAX);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy_a && busy_b && !cs_a, "R11 busy after start", busy_a, 1);
    pcs = cs_a;
    while (!((va + ta) > 0 && (vb + tb) > 0) && n < 20000) begin
      @(negedge clk); n++;
      if (poke && n == 30) start = 1; else start = 0;
      if (sclk_a) hr++;
      else if (hr > 0) begin if (hr != int'(dv) + 1) bad_hr++; hr = 0; end
      if (cs_a && sclk_a) bad_hr++;
      if (cs_a != pcs && sclk_a) bad_cs++;
      pcs = cs_a;
      if (val_a) begin va++; ra = res_a; ma = mm_a; end
      if (val_b) begin vb++; rb = res_b; mb = mm_b; end
      if (to_a) begin ta++; ra = res_a; end
      if (to_b) begin tb++; rb = res_b; end
    end
    start = 0;
    for (int i = 0; i < (poke ? 60 : 2); i++) begin
      @(negedge clk);
      if (val_a || val_b || to_a || to_b || !cs_a || !cs_b) extra++;
    end
    chk(bad_hr == 0, "R2 sclk high phase / idle", bad_hr, 0);
    chk(bad_cs == 0, "R3 cs_n moves only with sclk low", bad_cs, 0);
    if (poke) chk(extra == 0, "R10 start while busy ignored", extra, 0);
    else chk(extra == 0, "R8 single strobe per read", extra, 0);
    if (to_exp) begin
      chk(ta == 1 && va == 0, "R9 timeout A", ta, 1);
      chk(tb == 1 && vb == 0, "R9 timeout B", tb, 1);
      chk(ra == prev_a && rb == prev_b, "R9 result kept", ra, prev_a);
    end else begin
      chk(va == 1 && ta == 0, "R8 valid once A", va, 1);
      chk(ra == d, "R5 result A", ra, d);
      chk(rb == d, "R6 result B", rb, d);
      chk(ma == exp_mm(1'b1, fa), "R7 mismatch A", ma, exp_mm(1'b1, fa));
      chk(mb == exp_mm(1'b0, fb), "R7 mismatch B", mb, exp_mm(1'b0, fb));
      prev_a = ra; prev_b = rb;
    end
  endtask

  bit finished = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cs_a && !sclk_a && !val_a && !mm_a && !to_a && !busy_a, "R1 reset state in reset", cs_a, 1);
    rst_n = 1;
    @(negedge clk);
    chk(cs_b && !sclk_b && !val_b && !mm_b && !to_b && !busy_b, "R1 reset state after release", cs_b, 1);
    // R4 R5 R6: directed patterns
    run_frame(0, 12'hA5C, '0, '0, 8'd0, 0);
    run_frame(5, 12'hFFF, '0, '0, 8'd1, 0);
    run_frame(3, 12'h000, '0, '0, 8'd3, 0);
    // R7: corrupted copies; bit 0 is not re-sent when LSB_SHARED=0
    run_frame(2, 12'h3C1, 12'h001, 12'h001, 8'd0, 0);
    run_frame(1, 12'h801, 12'h800, 12'h400, 8'd2, 0);
    // R9 boundary
    run_frame(HUNT_MAX - 1, 12'h5A5, '0, '0, 8'd0, 0);
    run_frame(HUNT_MAX, 12'h123, '0, '0, 8'd0, 0);
    run_frame(HUNT_MAX + 4, 12'h321, '0, '0, 8'd1, 0);
    // R10
    run_frame(4, 12'h6E2, '0, '0, 8'd1, 1);
    for (int f = 0; f < 40; f++) begin
      logic [W-1:0] d, fa, fb;
      d = W'($urandom);
      fa = ($urandom_range(0, 2) == 0) ? W'(1) << $urandom_range(0, W - 1) : '0;
      fb = ($urandom_range(0, 2) == 0) ? W'(1) << $urandom_range(0, W - 1) : '0;
      run_frame($urandom_range(0, HUNT_MAX + 2), d, fa, fb, DIV_W'($urandom_range(0, 3)), 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule